// File: doc/BRIEF.md
# Card Presence and Reset Controller

This block supervises a removable flash card socket. It takes two active-low card-detect pins, brings each into the clock domain through a synchronizer and debounces it. It declares the card present only when both pins sit low. Every change of that presence flag raises a one-cycle detect event and latches a sticky status-changed flag. A new insertion starts a timed card reset pulse by itself, and software can extend that pulse by holding a reset bit in the mode register.

The mode register also selects the card access mode and holds the host-enable and output tri-state controls. While host enable is low, the pad drivers are disabled, the transfer logic downstream is held in soft reset and the presence flag is frozen. A presence change that is still pending when the host is enabled again produces its event at that point. A small synchronous register port reads back the status word and the mode register, and writes the mode register and clears the sticky flag.

Top module: `cardsock_ctrl`

## Requirements
- R1: The presence flag (`card_present`, status bit 7) is 1 only when both debounced detect levels are low. If either pin is high, the card is absent.
- R2: A detect pin's debounced level changes only after its synchronized value has differed from the current level for DEB_CYC consecutive cycles. Shorter pulses are ignored.
- R3: `detect_evt` pulses for exactly one cycle on every change of the presence flag. A pin change that leaves presence unchanged produces no pulse.
- R4: When presence goes from absent to present, `card_rst` goes high for exactly RST_CYC cycles and then falls.
- R5: Mode register bit 3 forces `card_rst` high for as long as the bit stays set, in addition to the timed pulse.
- R6: Mode register bits [1:0] decode one-hot as follows: 0 gives `mode_mem`, 1 gives `mode_io`, 2 gives `mode_ide`, and 3 asserts none of them.
- R7: Address 0 reads the status word. Bit 0 is the sticky status-changed flag, bit 2 is the debounced level of detect pin 1, bit 3 is detect pin 2, bit 5 is card-ready, bit 6 is I/O-ready and bit 7 is presence. All other bits read 0. The flag is set one cycle after each detect event and cleared by writing 1 to bit 0 at address 0; when both happen in the same cycle, the set wins.
- R8: Address 1 reads back mode bits [1:0], 3, 4 and 5 as last written, with all other bits 0. Reading returns data one cycle after the address is presented. The mode register resets to 0.
- R9: While mode bit 4 (host enable) is 0, `pad_oe` is 0, `xfer_clear` is 1, presence is frozen and no event is produced. After re-enabling, a pending presence change gives one event.
- R10: `pad_oe` is high only when host enable is 1 and mode bit 5 (tri-state) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| det1_n | input | 1 | Card-detect pin 1, active low, asynchronous |
| det2_n | input | 1 | Card-detect pin 2, active low, asynchronous |
| card_ready | input | 1 | Card ready level, asynchronous |
| io_ready | input | 1 | I/O ready level, asynchronous |
| reg_addr | input | 1 | Register select: 0 status, 1 mode |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| card_present | output | 1 | Qualified presence flag |
| detect_evt | output | 1 | One-cycle pulse on presence change |
| card_rst | output | 1 | Card reset output |
| host_en | output | 1 | Host enable from the mode register |
| pad_oe | output | 1 | Socket pad output enable |
| xfer_clear | output | 1 | Soft reset for transfer logic, high while host disabled |
| mode_mem | output | 1 | Memory mode selected |
| mode_io | output | 1 | I/O mode selected |
| mode_ide | output | 1 | True-IDE mode selected |

## Verification
The hardest situation to reach is a presence change that happens while the host is disabled and then shows up on re-enable. The stimulus first clears host enable and inserts the card. It checks that no event, no presence and no reset pulse appear, then sets host enable and expects exactly one event and one full reset pulse. A second difficult case is a detect pulse whose length sits right at the debounce threshold. The bench sweeps the pulse length from one cycle to a few cycles past DEB_CYC and predicts either zero or two events and either no reset pulse or a full one. Single-pin sequences cover the rule that both pins must be low for presence.

// File: rtl/csc_pkg.sv
package csc_pkg;

    typedef enum logic [1:0] {
        ACC_MEM  = 2'd0,
        ACC_IO   = 2'd1,
        ACC_IDE  = 2'd2,
        ACC_RSVD = 2'd3
    } acc_mode_e;

    typedef struct packed {
        logic      tri_pads;
        logic      host_en;
        logic      sw_rst;
        acc_mode_e acc;
    } mode_reg_t;

    localparam int MODE_SWRST_BIT = 3;
    localparam int MODE_HOST_BIT  = 4;
    localparam int MODE_TRI_BIT   = 5;

    localparam int STS_CHG_BIT  = 0;
    localparam int STS_DET1_BIT = 2;
    localparam int STS_DET2_BIT = 3;
    localparam int STS_RDY_BIT  = 5;
    localparam int STS_IORDY_BIT = 6;
    localparam int STS_PRES_BIT = 7;

    localparam int REG_W = 8;

endpackage

// File: rtl/csc_debounce.sv
module csc_debounce #(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_CYC     = 16,
    parameter bit RESET_VAL   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic level
);
    localparam int CW = (DEB_CYC > 1) ? $clog2(DEB_CYC) : 1;
    localparam logic [CW-1:0] CNT_MAX = CW'(DEB_CYC - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   stable;
        logic [CW-1:0]          cnt;
    } deb_t;

    deb_t st_d, st_q;
    logic sampled;

    assign sampled = st_q.sync[SYNC_STAGES-1];
    assign level   = st_q.stable;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], raw};
        if (sampled == st_q.stable) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CNT_MAX) begin
            st_d.stable = sampled;
            st_d.cnt    = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sync   <= {SYNC_STAGES{RESET_VAL}};
            st_q.stable <= RESET_VAL;
            st_q.cnt    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: level flips only after the counter has run its full window
    assert_level_after_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stable != $past(st_q.stable)) |-> ($past(st_q.cnt) == CNT_MAX));

    // R2: agreement between sample and level restarts the window
    assert_window_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sampled == st_q.stable) |=> (st_q.cnt == '0));

endmodule

// File: rtl/csc_reset_timer.sv
module csc_reset_timer #(
    parameter int RST_CYC = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic hold,
    output logic rst_out
);
    localparam int TW = $clog2(RST_CYC + 1);
    localparam logic [TW-1:0] LOAD = TW'(RST_CYC);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (start)
            t_d.cnt = LOAD;
        else if (t_q.cnt != '0)
            t_d.cnt = t_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q.cnt <= '0;
        else        t_q     <= t_d;
    end

    assign rst_out = (t_q.cnt != '0) | hold;

    // R4: a start always produces an asserted reset on the next cycle
    assert_start_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> rst_out);

    // R4: the down-counter never exceeds its load value
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.cnt <= LOAD);

    // R5: software hold is always visible on the output
    assert_hold_visible_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> rst_out);

endmodule

// File: rtl/csc_regs.sv
module csc_regs
    import csc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    input  logic             chg_set,
    input  logic [REG_W-1:0] sts_in,
    output logic [REG_W-1:0] rdata,
    output mode_reg_t        mode
);
    typedef struct packed {
        mode_reg_t        mode;
        logic             chg;
        logic [REG_W-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;
    logic  clr_hit;
    logic [REG_W-1:0] mode_word;
    logic [REG_W-1:0] sts_word;

    assign clr_hit = we && !addr && wdata[STS_CHG_BIT];

    always_comb begin
        mode_word                 = '0;
        mode_word[1:0]            = r_q.mode.acc;
        mode_word[MODE_SWRST_BIT] = r_q.mode.sw_rst;
        mode_word[MODE_HOST_BIT]  = r_q.mode.host_en;
        mode_word[MODE_TRI_BIT]   = r_q.mode.tri_pads;

        sts_word              = '0;
        sts_word[STS_DET1_BIT]  = sts_in[STS_DET1_BIT];
        sts_word[STS_DET2_BIT]  = sts_in[STS_DET2_BIT];
        sts_word[STS_RDY_BIT]   = sts_in[STS_RDY_BIT];
        sts_word[STS_IORDY_BIT] = sts_in[STS_IORDY_BIT];
        sts_word[STS_PRES_BIT]  = sts_in[STS_PRES_BIT];
        sts_word[STS_CHG_BIT]   = r_q.chg;
    end

    always_comb begin
        r_d = r_q;
        if (we && addr) begin
            r_d.mode.acc      = acc_mode_e'(wdata[1:0]);
            r_d.mode.sw_rst   = wdata[MODE_SWRST_BIT];
            r_d.mode.host_en  = wdata[MODE_HOST_BIT];
            r_d.mode.tri_pads = wdata[MODE_TRI_BIT];
        end
        if (chg_set)
            r_d.chg = 1'b1;
        else if (clr_hit)
            r_d.chg = 1'b0;
        r_d.rdata = addr ? mode_word : sts_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.mode  <= '0;
            r_q.chg   <= 1'b0;
            r_q.rdata <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rdata = r_q.rdata;
    assign mode  = r_q.mode;

    // R7: a set request always leaves the sticky flag high
    assert_chg_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chg_set |=> r_q.chg);

    // R7: the flag drops only after a clear write with no concurrent set
    assert_chg_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.chg) |-> $past(clr_hit && !chg_set));

endmodule

// File: rtl/cardsock_ctrl.sv
module cardsock_ctrl
    import csc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_CYC     = 16,
    parameter int RST_CYC     = 25000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       det1_n,
    input  logic       det2_n,
    input  logic       card_ready,
    input  logic       io_ready,
    input  logic       reg_addr,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       card_present,
    output logic       detect_evt,
    output logic       card_rst,
    output logic       host_en,
    output logic       pad_oe,
    output logic       xfer_clear,
    output logic       mode_mem,
    output logic       mode_io,
    output logic       mode_ide
);
    localparam int NUM_IN  = 4;
    localparam int NUM_DET = 2;

    logic [NUM_IN-1:0] in_raw;
    logic [NUM_IN-1:0] in_lvl;

    assign in_raw = {io_ready, card_ready, det2_n, det1_n};

    genvar gi;
    generate
        for (gi = 0; gi < NUM_IN; gi++) begin : g_in
            if (gi < NUM_DET) begin : g_det
                csc_debounce #(
                    .SYNC_STAGES(SYNC_STAGES),
                    .DEB_CYC    (DEB_CYC),
                    .RESET_VAL  (1'b1)
                ) u_deb (
                    .clk  (clk),
                    .rst_n(rst_n),
                    .raw  (in_raw[gi]),
                    .level(in_lvl[gi])
                );
            end else begin : g_lvl
                csc_debounce #(
                    .SYNC_STAGES(SYNC_STAGES),
                    .DEB_CYC    (1),
                    .RESET_VAL  (1'b0)
                ) u_deb (
                    .clk  (clk),
                    .rst_n(rst_n),
                    .raw  (in_raw[gi]),
                    .level(in_lvl[gi])
                );
            end
        end
    endgenerate

    typedef struct packed {
        logic pres;
        logic evt;
    } pres_t;

    pres_t     p_d, p_q;
    mode_reg_t mode;
    logic      raw_pres;
    logic      insert_start;
    logic [REG_W-1:0] sts_in;

    assign raw_pres = ~|in_lvl[NUM_DET-1:0];

    always_comb begin
        p_d          = p_q;
        p_d.evt      = 1'b0;
        insert_start = 1'b0;
        if (mode.host_en && (raw_pres != p_q.pres)) begin
            p_d.pres     = raw_pres;
            p_d.evt      = 1'b1;
            insert_start = raw_pres;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q.pres <= 1'b0;
            p_q.evt  <= 1'b0;
        end else begin
            p_q <= p_d;
        end
    end

    always_comb begin
        sts_in                = '0;
        sts_in[STS_DET1_BIT]  = in_lvl[0];
        sts_in[STS_DET2_BIT]  = in_lvl[1];
        sts_in[STS_RDY_BIT]   = in_lvl[2];
        sts_in[STS_IORDY_BIT] = in_lvl[3];
        sts_in[STS_PRES_BIT]  = p_q.pres;
    end

    csc_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (reg_addr),
        .we     (reg_we),
        .wdata  (reg_wdata),
        .chg_set(p_q.evt),
        .sts_in (sts_in),
        .rdata  (reg_rdata),
        .mode   (mode)
    );

    csc_reset_timer #(.RST_CYC(RST_CYC)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (insert_start),
        .hold   (mode.sw_rst),
        .rst_out(card_rst)
    );

    assign card_present = p_q.pres;
    assign detect_evt   = p_q.evt;
    assign host_en      = mode.host_en;
    assign pad_oe       = mode.host_en & ~mode.tri_pads;
    assign xfer_clear   = ~mode.host_en;
    assign mode_mem     = (mode.acc == ACC_MEM);
    assign mode_io      = (mode.acc == ACC_IO);
    assign mode_ide     = (mode.acc == ACC_IDE);

    // R1: presence rises only from two low debounced detect levels
    assert_pres_both_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(p_q.pres) |-> $past(!in_lvl[0] && !in_lvl[1]));

    // R3: an event is never followed directly by another event
    assert_evt_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        p_q.evt |=> !p_q.evt);

    // R4: card reset is driven in the cycle presence rises
    assert_rst_on_insert_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(p_q.pres) |-> card_rst);

    // R9: presence stays frozen while the host is disabled
    assert_frozen_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mode.host_en |=> $stable(p_q.pres));

    // R6: at most one mode decode is active
    assert_mode_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mode_mem, mode_io, mode_ide}));

endmodule

// File: tb/cardsock_ctrl_bench.sv
module cardsock_ctrl_bench;
    localparam int DEB = 4;
    localparam int RST = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       det1_n = 1'b1, det2_n = 1'b1;
    logic       card_ready = 1'b0, io_ready = 1'b0;
    logic       reg_addr = 1'b0, reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       card_present, detect_evt, card_rst, host_en, pad_oe, xfer_clear;
    logic       mode_mem, mode_io, mode_ide;

    int total = 0;
    int bad   = 0;
    int evt_cnt = 0;
    int rst_cnt = 0;

    always #4 clk = ~clk;

    cardsock_ctrl #(.SYNC_STAGES(2), .DEB_CYC(DEB), .RST_CYC(RST)) u_cardsock_ctrl (
        .clk(clk), .rst_n(rst_n), .det1_n(det1_n), .det2_n(det2_n),
        .card_ready(card_ready), .io_ready(io_ready),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .card_present(card_present), .detect_evt(detect_evt),
        .card_rst(card_rst), .host_en(host_en), .pad_oe(pad_oe),
        .xfer_clear(xfer_clear), .mode_mem(mode_mem), .mode_io(mode_io),
        .mode_ide(mode_ide)
    );

    always @(posedge clk) begin
        if (rst_n && detect_evt) evt_cnt++;
        if (rst_n && card_rst)   rst_cnt++;
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_counts();
        @(negedge clk);
        evt_cnt = 0;
        rst_cnt = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // reset state (R8, R9)
        check("R8 reset card_present", card_present, 0);
        check("R4 reset card_rst", card_rst, 0);
        check("R9 reset pad_oe", pad_oe, 0);
        check("R9 reset xfer_clear", xfer_clear, 1);
        check("R6 reset mode_mem", mode_mem, 1);
        rd(1'b1, d);
        check("R8 reset mode readback", d, 0);

        wr(1'b1, 8'h12);
        check("R10 pad_oe enabled", pad_oe, 1);
        check("R9 xfer_clear released", xfer_clear, 0);

        // R2 R3 R4 glitch-length sweep on both pins together
        for (int len = 1; len <= DEB + 2; len++) begin
            clr_counts();
            det1_n = 1'b0; det2_n = 1'b0;
            idle(len);
            det1_n = 1'b1; det2_n = 1'b1;
            idle(RST + 3 * DEB + 10);
            check($sformatf("R2 R3 events len=%0d", len), evt_cnt, (len >= DEB) ? 2 : 0);
            check($sformatf("R4 reset width len=%0d", len), rst_cnt, (len >= DEB) ? RST : 0);
            check("R1 absent after release", card_present, 0);
        end

        // R1 R3 single-pin sequences
        clr_counts();
        det1_n = 1'b0;
        idle(DEB + 8);
        check("R1 one pin low absent", card_present, 0);
        check("R3 one pin no event", evt_cnt, 0);
        det2_n = 1'b0;
        idle(DEB + 8);
        check("R1 both low present", card_present, 1);
        check("R3 insert event", evt_cnt, 1);
        idle(RST);
        det1_n = 1'b1;
        idle(DEB + 8);
        check("R1 one pin high absent", card_present, 0);
        check("R3 removal event", evt_cnt, 2);
        det2_n = 1'b1;
        idle(DEB + 8);
        check("R3 same state no event", evt_cnt, 2);

        // R7 sticky flag set, then clear
        rd(1'b0, d);
        check("R7 chg flag set", d[0], 1);
        wr(1'b0, 8'h01);
        rd(1'b0, d);
        check("R7 chg flag cleared", d[0], 0);

        // R7 status sweep over pins and ready lines
        for (int v = 0; v < 16; v++) begin
            det1_n = v[0]; det2_n = v[1]; card_ready = v[2]; io_ready = v[3];
            idle(RST + DEB + 10);
            rd(1'b0, d);
            check($sformatf("R7 status v=%0d", v), {d[7:1], 1'b0},
                  {(v[1:0] == 2'b00), v[3], v[2], 1'b0, v[1], v[0], 1'b0, 1'b0});
            wr(1'b0, 8'h01);
        end
        det1_n = 1'b1; det2_n = 1'b1; card_ready = 1'b0; io_ready = 1'b0;
        idle(DEB + 8);

        // R9 host disabled: insertion is held pending
        wr(1'b1, 8'h02);
        clr_counts();
        det1_n = 1'b0; det2_n = 1'b0;
        idle(DEB + 20);
        check("R9 no event while disabled", evt_cnt, 0);
        check("R9 presence frozen", card_present, 0);
        check("R9 pad_oe low", pad_oe, 0);
        check("R9 xfer_clear high", xfer_clear, 1);
        check("R9 no reset pulse", rst_cnt, 0);
        wr(1'b1, 8'h12);
        idle(RST + 5);
        check("R9 pending event on enable", evt_cnt, 1);
        check("R9 presence after enable", card_present, 1);
        check("R4 reset pulse after enable", rst_cnt, RST);

        // R5 software hold of card reset
        check("R5 reset idle", card_rst, 0);
        wr(1'b1, 8'h1A);
        idle(RST + 10);
        check("R5 reset held", card_rst, 1);
        wr(1'b1, 8'h12);
        check("R5 reset released", card_rst, 0);

        // R6 R8 mode decode sweep
        for (int m = 0; m < 4; m++) begin
            wr(1'b1, 8'h10 | 8'(m));
            check($sformatf("R6 mem m=%0d", m), mode_mem, (m == 0) ? 1 : 0);
            check($sformatf("R6 io m=%0d", m), mode_io, (m == 1) ? 1 : 0);
            check($sformatf("R6 ide m=%0d", m), mode_ide, (m == 2) ? 1 : 0);
            rd(1'b1, d);
            check($sformatf("R8 readback m=%0d", m), d, 8'h10 | m);
        end
        wr(1'b1, 8'hFF);
        rd(1'b1, d);
        check("R8 unused bits zero", d, 8'h3B);

        // R10 tri-state control
        wr(1'b1, 8'h30);
        check("R10 tristate pad_oe", pad_oe, 0);
        check("R10 host still enabled", host_en, 1);
        wr(1'b1, 8'h10);
        check("R10 pads driven", pad_oe, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule